// File: doc/BRIEF.md
# System configuration register file

A bank of eleven 32-bit configuration words sitting on a plain word-addressed bus: byte offset, write enable, write data and a combinational read path. Each bit of each word carries its own access policy. Some fields are ordinary read/write. Some bits can only be set and are cleared only by reset. One bit can only be cleared, and reset restores it. One status flag is raised by a hardware event, cleared by software writing 1, and never raised by a software write. Every bit that has no policy is reserved: it reads zero and cannot be changed.

Four of the words hold 16-bit interrupt-line source selectors. Their contents drive an output bus that an external line multiplexer decodes. The hardware features that the other words steer live outside this block and are not modelled.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset every word reads 0x00000000, except offset 0x04, which reads 0x7C000001.
- R2: At offset 0x00, bits 8 and 2:0 are read/write and all other bits read zero. Offset 0x18 has no writable bits and always reads zero.
- R3: At offset 0x04, bits 31:26, 23:16 and 8 are read/write. Every other bit except bit 0 reads zero.
- R4: Bit 0 of offset 0x04 is cleared by writing 0 to it. Writing 1 never sets it again; only reset does.
- R5: The selector words at offsets 0x08, 0x0C, 0x10 and 0x14 have bits 15:0 read/write and bits 31:16 reading zero. Bits 15:0 of the selector at offset 0x08+4k appear on `line_sel_o[16k+15:16k]`.
- R6: At offset 0x24, bits 7:0 are read/write and all other bits read zero.
- R7: At offset 0x1C, bits 3:0 are set-only: writing 1 sets a bit and writing 0 leaves it unchanged.
- R8: Bit 8 of offset 0x1C is set by a high `err_evt_i` at a clock edge and cleared by a software write with bit 8 at 1. A software write can never set it. When an event and a clearing write fall on the same edge, the bit ends up set.
- R9: The words at offsets 0x20 and 0x28 are set-only in all 32 bits. Only reset clears them.
- R10: Misaligned offsets and offsets from 0x2C upward read zero, and writes to them change no word.
- R11: A write takes effect at the rising clock edge on which `wr_en_i` is high. Reads reflect the current word state combinationally, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (8) | Byte offset of the accessed word |
| wr_en_i | input | 1 | Write strobe for the current offset |
| wr_data_i | input | 32 | Data to write |
| err_evt_i | input | 1 | Hardware event that raises the status flag |
| rd_data_o | output | 32 | Read data for the current offset |
| line_sel_o | output | 64 | Four 16-bit interrupt-line selector fields |

## Verification
A write, and an event on `err_evt_i`, shows up in `rd_data_o` and `line_sel_o` after the first rising edge at which it is presented. A read of a given offset is valid in the same cycle that the offset is applied. The bench changes inputs on falling edges. Its reference model advances at each rising edge and is compared with both outputs 2 ns after that edge. Directed reads apply the offset and sample 1 ns later, and one check confirms that a write in progress still reads the old value before its edge.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int DATA_W    = 32;
    localparam int REG_COUNT = 11;
    localparam int SEL_W     = 16;
    localparam int NUM_SEL   = 4;
    localparam int SEL_BASE  = 2;
    localparam int LOCK_IDX  = 7;
    localparam int FLAG_BIT  = 8;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t rst;
        word_t rw;
        word_t so;
        word_t co;
        word_t w1c;
    } policy_t;

    function automatic policy_t policy_of(int idx);
        policy_t p;
        p = '0;
        case (idx)
            0: p.rw = 32'h0000_0107;
            1: begin
                p.rst = 32'h7C00_0001;
                p.rw  = 32'hFCFF_0100;
                p.co  = 32'h0000_0001;
            end
            2, 3, 4, 5: p.rw = 32'h0000_FFFF;
            7: begin
                p.so  = 32'h0000_000F;
                p.w1c = 32'h0000_0100;
            end
            8, 10: p.so = 32'hFFFF_FFFF;
            9: p.rw = 32'h0000_00FF;
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
    import cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 hit_o,
    output logic [REG_COUNT-1:0] sel_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;

    assign idx   = addr_i[ADDR_W-1:2];
    assign hit_o = (addr_i[1:0] == 2'b00) && (int'(idx) < REG_COUNT);

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
        assign sel_o[i] = hit_o && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/cfg_word.sv
module cfg_word
    import cfg_pkg::*;
#(
    parameter word_t RST_VAL = '0,
    parameter word_t RW_MSK  = '0,
    parameter word_t SO_MSK  = '0,
    parameter word_t CO_MSK  = '0,
    parameter word_t W1C_MSK = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  word_t wdata_i,
    input  word_t hw_set_i,
    output word_t q_o
);
    localparam word_t RESV_MSK = ~(RW_MSK | SO_MSK | CO_MSK | W1C_MSK);

    typedef struct packed {
        word_t word;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.word = (state_q.word & ~RW_MSK) | (wdata_i & RW_MSK);
            state_d.word = state_d.word | (wdata_i & SO_MSK);
            state_d.word = state_d.word & ~(~wdata_i & CO_MSK);
            state_d.word = state_d.word & ~(wdata_i & W1C_MSK);
        end
        // hardware event wins over a same-edge software clear
        state_d.word = state_d.word | (hw_set_i & W1C_MSK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{word: RST_VAL};
        else        state_q <= state_d;
    end

    assign q_o = state_q.word;

    // reserved bits stay zero (also covers R3, R5, R6)
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o & RESV_MSK) == '0);

    // set-only bits never fall (also covers R7)
    assert_set_only_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(q_o) & SO_MSK & ~q_o) == '0));

    assert_clear_only_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(q_o) & CO_MSK & q_o) == '0));

    assert_flag_no_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set_i & W1C_MSK) == '0) |=> ((~$past(q_o) & W1C_MSK & q_o) == '0));

endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
    import cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     wr_en_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic                     err_evt_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic [NUM_SEL*SEL_W-1:0] line_sel_o
);
    logic                             hit;
    logic [REG_COUNT-1:0]             sel;
    logic [REG_COUNT-1:0][DATA_W-1:0] words;

    cfg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr_i),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_word
        localparam policy_t P = policy_of(i);
        word_t hw_set;

        if (i == LOCK_IDX) begin : g_evt
            assign hw_set = word_t'(err_evt_i) << FLAG_BIT;
        end else begin : g_no_evt
            assign hw_set = '0;
        end

        cfg_word #(
            .RST_VAL (P.rst),
            .RW_MSK  (P.rw),
            .SO_MSK  (P.so),
            .CO_MSK  (P.co),
            .W1C_MSK (P.w1c)
        ) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (wr_en_i && sel[i]),
            .wdata_i  (wr_data_i),
            .hw_set_i (hw_set),
            .q_o      (words[i])
        );
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (sel[i]) rd_data_o = rd_data_o | words[i];
        end
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_line
        assign line_sel_o[k*SEL_W +: SEL_W] = words[SEL_BASE+k][SEL_W-1:0];
    end

    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !hit && !err_evt_i) |=> $stable(words));

    assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rd_data_o == '0));

endmodule

// File: tb/sys_cfg_regs_bench.sv
module sys_cfg_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        evt = 1'b0;
    logic [31:0] rdata;
    logic [63:0] lsel;

    int tests = 0;
    int fails = 0;
    logic [31:0] model [11];

    always #5 clk = ~clk;

    sys_cfg_regs u_sys_cfg_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .wr_data_i  (wdata),
        .err_evt_i  (evt),
        .rd_data_o  (rdata),
        .line_sel_o (lsel)
    );

    function automatic logic [31:0] rst_val(int i);
        return (i == 1) ? 32'h7C00_0001 : 32'h0;
    endfunction

    function automatic logic [31:0] model_write(int i, logic [31:0] q, logic [31:0] w);
        logic [31:0] n;
        n = q;
        case (i)
            0: n = w & 32'h107;
            1: n = (w & 32'hFCFF_0100) | (q & w & 32'h1);
            2, 3, 4, 5: n = w & 32'hFFFF;
            7: begin
                n = q | (w & 32'hF);
                if (w[8]) n[8] = 1'b0;
            end
            8, 10: n = q | w;
            9: n = w & 32'hFF;
            default: n = 32'h0;
        endcase
        return n;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a[1:0] != 2'b00 || a[7:2] > 6'd10) return 32'h0;
        return model[int'(a[7:2])];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle reference comparison (R11 timing, R5 export)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 11; i++) model[i] = rst_val(i);
        end else begin
            if (wr_en && addr[1:0] == 2'b00 && addr[7:2] <= 6'd10)
                model[int'(addr[7:2])] = model_write(int'(addr[7:2]), model[int'(addr[7:2])], wdata);
            if (evt) model[7][8] = 1'b1;
        end
        #2;
        check("R11 per-cycle read", rdata, model_read(addr));
        check("R5 per-cycle line_sel", lsel[31:0], {model[3][15:0], model[2][15:0]});
        check("R5 per-cycle line_sel hi", lsel[63:32], {model[5][15:0], model[4][15:0]});
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        for (int i = 0; i < 11; i++)
            rd_check("R1", 8'(i * 4), (i == 1) ? 32'h7C00_0001 : 32'h0);
        rd_check("R10 offset 0x2C", 8'h2C, 32'h0);

        // R2
        wr(8'h00, 32'hFFFF_FEF8); rd_check("R2 reserved", 8'h00, 32'h0);
        wr(8'h00, 32'h0000_0107); rd_check("R2 rw", 8'h00, 32'h107);
        wr(8'h18, 32'hFFFF_FFFF); rd_check("R2 offset 0x18", 8'h18, 32'h0);

        // R3 / R4
        wr(8'h04, 32'h7F00_FEFF); rd_check("R3 reserved", 8'h04, 32'h7C00_0001);
        wr(8'h04, 32'hFCFF_0101); rd_check("R3 rw", 8'h04, 32'hFCFF_0101);
        wr(8'h04, 32'h0);         rd_check("R4 clear", 8'h04, 32'h0);
        wr(8'h04, 32'h1);         rd_check("R4 no reset by write", 8'h04, 32'h0);

        // R5
        wr(8'h08, 32'hFFFF_0010); rd_check("R5 sel0", 8'h08, 32'h10);
        check("R5 line_sel field 0", {16'h0, lsel[15:0]}, 32'h10);
        wr(8'h14, 32'h0000_ABCD);
        @(negedge clk); #1;
        check("R5 line_sel field 3", {16'h0, lsel[63:48]}, 32'hABCD);

        // R6
        wr(8'h24, 32'hFFFF_FF5A); rd_check("R6", 8'h24, 32'h5A);

        // R7
        wr(8'h1C, 32'h5); wr(8'h1C, 32'h2); wr(8'h1C, 32'h0);
        rd_check("R7 set-only", 8'h1C, 32'h7);

        // R8
        wr(8'h1C, 32'h100); rd_check("R8 no sw set", 8'h1C, 32'h7);
        @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
        rd_check("R8 hw set", 8'h1C, 32'h107);
        wr(8'h1C, 32'h100); rd_check("R8 w1c", 8'h1C, 32'h7);
        @(negedge clk); addr = 8'h1C; wdata = 32'h100; wr_en = 1'b1; evt = 1'b1;
        @(negedge clk); wr_en = 1'b0; evt = 1'b0;
        rd_check("R8 event wins", 8'h1C, 32'h107);

        // R9
        wr(8'h20, 32'hF0F0_F0F0); wr(8'h20, 32'h0F0F_0F0F); wr(8'h20, 32'h0);
        rd_check("R9 low word", 8'h20, 32'hFFFF_FFFF);
        wr(8'h28, 32'h1); wr(8'h28, 32'h0);
        rd_check("R9 high word", 8'h28, 32'h1);

        // R10
        wr(8'h2C, 32'hFFFF_FFFF); rd_check("R10 0x2C", 8'h2C, 32'h0);
        wr(8'h25, 32'h11);        rd_check("R10 misaligned kept", 8'h24, 32'h5A);
        rd_check("R10 misaligned read", 8'h25, 32'h0);
        rd_check("R10 0xFC", 8'hFC, 32'h0);

        // R11 timing
        @(negedge clk); addr = 8'h24; wdata = 32'h33; wr_en = 1'b1;
        #1; check("R11 before edge", rdata, 32'h5A);
        @(posedge clk); #1; check("R11 after edge", rdata, 32'h33);
        @(negedge clk); wr_en = 1'b0;

        // R1 after second reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_check("R1 reset 0x04", 8'h04, 32'h7C00_0001);
        rd_check("R1 reset 0x20", 8'h20, 32'h0);
        rd_check("R1 reset 0x1C", 8'h1C, 32'h0);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule